// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block sits between a CPU and its interrupt sources. It takes one non-maskable line, a set of external request lines and a set of internal peripheral request lines. A rising edge on any of these lines records a pending event for that source. The pending event stays recorded until the CPU acknowledges the vector that belongs to it. Each cycle, the pending events are filtered into a set of accepted requests:

- The non-maskable event is always accepted.
- A maskable event is accepted only when its own enable bit is set and the CPU's global mask flag is clear.

A fixed-priority arbiter picks one accepted request and presents it to the CPU as a request strobe with a 6-bit vector number.

The CPU answers by pulsing the acknowledge input together with the vector it has taken. This clears that one pending event. A request that loses arbitration, or that is held back by its enable or by the global mask, is not dropped. It stays recorded and is presented once it becomes the highest-priority accepted request. The request and vector outputs are registered. Their values are computed from the pending state as it will be after the current edge, so the effect of a new edge, an acknowledge, an enable change or a mask change appears at the output on the first clock edge that samples it.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While reset is asserted and after its release with all request lines low, `irq_o` is 0 and `vec_o` is 0.
- R2: A 0-to-1 transition on a request line, as sampled at a clock edge, records a pending event for that source. A line held high records no further event after its pending event has been acknowledged.
- R3: A maskable source is presented only when its enable bit is 1 and `gmask_i` is 0. A disabled source keeps its pending event and is presented after its enable is set.
- R4: When `gmask_i` is 1, no maskable source is presented. Maskable pending events are kept and are presented after `gmask_i` returns to 0.
- R5: A pending non-maskable event is presented regardless of `gmask_i` and of every enable bit.
- R6: Fixed priority when several requests are accepted, highest first: the non-maskable source, then external lines with index 0 first, then internal sources with index 0 first.
- R7: Vector encoding on 6 bits: the non-maskable source is 3, external line k is 4+k, and internal source j is 4+N_EXT+j. `vec_o` is 0 whenever `irq_o` is 0.
- R8: Accepted requests that lose arbitration stay pending. Each is presented in priority order as the ones above it are acknowledged.
- R9: A cycle with `ack_i`=1 clears only the pending event whose vector equals `ack_vec_i`. An acknowledge naming a vector with no pending event changes nothing at the outputs.
- R10: If a new rising edge on a source and an acknowledge of that source's vector occur in the same cycle, the event stays pending.
- R11: `irq_o` and `vec_o` are registered. They reflect a change of the request lines, enables, mask or acknowledge on the first rising clock edge at which that change is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| nmi_i | input | 1 | Non-maskable request line, edge sensitive |
| ext_req_i | input | N_EXT | External request lines, edge sensitive |
| per_req_i | input | N_INT | Internal peripheral request lines, edge sensitive |
| ext_en_i | input | N_EXT | Per-line enables for the external sources |
| per_en_i | input | N_INT | Per-source enables for the internal sources |
| gmask_i | input | 1 | Global mask flag from the CPU; 1 blocks all maskable sources |
| ack_i | input | 1 | Acknowledge strobe from the CPU |
| ack_vec_i | input | 6 | Vector being acknowledged |
| irq_o | output | 1 | Request strobe to the CPU |
| vec_o | output | 6 | Vector number of the presented request |

## Verification
The hardest situation to reach from the ports is a pending event that has to survive several cycles in which something else owns the output. Examples are a loser of arbitration, a source held back by the global mask while the non-maskable line is served, and a source whose new edge coincides with its own acknowledge. The stimulus builds these cases by raising several lines in one cycle, setting the mask before a line rises, and timing an acknowledge onto the same cycle as a fresh edge. It then acknowledges the winners one at a time, so that each stored event has to reappear in priority order. Level-held lines and acknowledges of vectors that are not pending are mixed in, to show that neither creates nor removes an event.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  localparam int unsigned VEC_W = 6;

  // Vector number of source idx (0 = non-maskable, then external, then internal).
  function automatic logic [VEC_W-1:0] src_vector(input int unsigned idx,
                                                  input int unsigned base);
    return VEC_W'(base + idx);
  endfunction

  // A maskable source may pass only if enabled and the global mask is clear.
  function automatic logic maskable_pass(input logic pend,
                                         input logic en,
                                         input logic gmask);
    return pend & en & ~gmask;
  endfunction

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
  import irq_prio_pkg::*;
#(
  parameter int unsigned NSRC     = 13,
  parameter int unsigned VEC_BASE = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  raw_i,
  input  logic             ack_i,
  input  logic [VEC_W-1:0] ack_vec_i,
  output logic [NSRC-1:0]  pend_nx_o,
  output logic [NSRC-1:0]  pend_q_o
);

  logic [NSRC-1:0] raw_prev;
  logic [NSRC-1:0] rise;
  logic [NSRC-1:0] clr;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign rise[i] = raw_i[i] & ~raw_prev[i];
    assign clr[i]  = ack_i && (ack_vec_i == src_vector(i, VEC_BASE));
    // A new edge wins over an acknowledge in the same cycle.
    assign pend_nx_o[i] = rise[i] | (pend_q_o[i] & ~clr[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        raw_prev[i] <= 1'b0;
        pend_q_o[i] <= 1'b0;
      end else begin
        raw_prev[i] <= raw_i[i];
        pend_q_o[i] <= pend_nx_o[i];
      end
    end
  end

endmodule

// File: rtl/irq_accept_gate.sv
module irq_accept_gate
  import irq_prio_pkg::*;
#(
  parameter int unsigned NSRC = 13
) (
  input  logic [NSRC-1:0] pend_i,
  input  logic [NSRC-1:0] en_i,
  input  logic            gmask_i,
  output logic [NSRC-1:0] accept_o
);

  // Source 0 is non-maskable: it ignores both its enable and the global mask.
  assign accept_o[0] = pend_i[0];

  for (genvar i = 1; i < NSRC; i++) begin : g_mask
    assign accept_o[i] = maskable_pass(pend_i[i], en_i[i], gmask_i);
  end

endmodule

// File: rtl/irq_fixed_arb.sv
module irq_fixed_arb
  import irq_prio_pkg::*;
#(
  parameter int unsigned NSRC     = 13,
  parameter int unsigned VEC_BASE = 3
) (
  input  logic [NSRC-1:0]  accept_i,
  output logic [NSRC-1:0]  win_o,
  output logic [VEC_W-1:0] vec_o
);

  logic found;

  // Lowest index wins.
  always_comb begin
    win_o = '0;
    vec_o = '0;
    found = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (accept_i[i] && !found) begin
        win_o[i] = 1'b1;
        vec_o    = src_vector(i, VEC_BASE);
        found    = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int unsigned N_EXT    = 4,
  parameter int unsigned N_INT    = 8,
  parameter int unsigned VEC_BASE = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nmi_i,
  input  logic [N_EXT-1:0] ext_req_i,
  input  logic [N_INT-1:0] per_req_i,
  input  logic [N_EXT-1:0] ext_en_i,
  input  logic [N_INT-1:0] per_en_i,
  input  logic             gmask_i,
  input  logic             ack_i,
  input  logic [VEC_W-1:0] ack_vec_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] vec_o
);

  localparam int unsigned NSRC = 1 + N_EXT + N_INT;

  // Named internal events, brought out for the checker.
  logic [NSRC-1:0]  raw_all;
  logic [NSRC-1:0]  en_all;
  logic [NSRC-1:0]  pend_nx;
  logic [NSRC-1:0]  pend_q;
  logic [NSRC-1:0]  accept;
  logic [NSRC-1:0]  win_onehot;
  logic [VEC_W-1:0] win_vec;
  logic             any_win;

  assign raw_all = {per_req_i, ext_req_i, nmi_i};
  assign en_all  = {per_en_i, ext_en_i, 1'b1};

  irq_pend_bank #(.NSRC(NSRC), .VEC_BASE(VEC_BASE)) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .raw_i     (raw_all),
    .ack_i     (ack_i),
    .ack_vec_i (ack_vec_i),
    .pend_nx_o (pend_nx),
    .pend_q_o  (pend_q)
  );

  irq_accept_gate #(.NSRC(NSRC)) u_gate (
    .pend_i   (pend_nx),
    .en_i     (en_all),
    .gmask_i  (gmask_i),
    .accept_o (accept)
  );

  irq_fixed_arb #(.NSRC(NSRC), .VEC_BASE(VEC_BASE)) u_arb (
    .accept_i (accept),
    .win_o    (win_onehot),
    .vec_o    (win_vec)
  );

  assign any_win = |win_onehot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o <= 1'b0;
      vec_o <= '0;
    end else begin
      irq_o <= any_win;
      vec_o <= any_win ? win_vec : '0;
    end
  end

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
  import irq_prio_pkg::*;
#(
  parameter int unsigned NSRC     = 13,
  parameter int unsigned VEC_BASE = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gmask_i,
  input logic             ack_i,
  input logic [VEC_W-1:0] ack_vec_i,
  input logic             irq_o,
  input logic [VEC_W-1:0] vec_o,
  input logic [NSRC-1:0]  pend_q,
  input logic [NSRC-1:0]  win_onehot
);

  // R4
  mask_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gmask_i |=> (!irq_o || vec_o == VEC_W'(VEC_BASE)));

  // R7
  idle_vec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> vec_o == '0);

  // R7
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (vec_o >= VEC_W'(VEC_BASE) && vec_o < VEC_W'(VEC_BASE + NSRC)));

  // R6
  single_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_onehot));

  // R5
  nmi_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q[0] && !(ack_i && ack_vec_i == VEC_W'(VEC_BASE)))
      |=> (irq_o && vec_o == VEC_W'(VEC_BASE)));

  for (genvar i = 0; i < NSRC; i++) begin : g_hold
    // R8
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[i] && !(ack_i && ack_vec_i == src_vector(i, VEC_BASE)))
        |=> pend_q[i]);
  end

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NSRC(NSRC), .VEC_BASE(VEC_BASE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .gmask_i    (gmask_i),
  .ack_i      (ack_i),
  .ack_vec_i  (ack_vec_i),
  .irq_o      (irq_o),
  .vec_o      (vec_o),
  .pend_q     (pend_q),
  .win_onehot (win_onehot)
);

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;

  localparam int NE   = 4;
  localparam int NI   = 8;
  localparam int BASE = 3;
  localparam int NS   = 1 + NE + NI;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          nmi = 1'b0;
  logic [NE-1:0] ext = '0;
  logic [NI-1:0] per = '0;
  logic [NE-1:0] ext_en = '0;
  logic [NI-1:0] per_en = '0;
  logic          gmask = 1'b0;
  logic          ack = 1'b0;
  logic [5:0]    ackv = '0;
  logic          irq;
  logic [5:0]    vec;

  int total = 0;
  int fails = 0;
  bit done  = 0;

  typedef struct {
    logic       irq;
    logic [5:0] vec;
    string      tag;
  } exp_t;

  exp_t sb[$];
  bit pend_m[NS];
  bit prev_m[NS];

  always #10 clk = ~clk;

  irq_prio_ctrl #(.N_EXT(NE), .N_INT(NI), .VEC_BASE(BASE)) uut (
    .clk(clk), .rst_n(rst_n), .nmi_i(nmi), .ext_req_i(ext), .per_req_i(per),
    .ext_en_i(ext_en), .per_en_i(per_en), .gmask_i(gmask), .ack_i(ack),
    .ack_vec_i(ackv), .irq_o(irq), .vec_o(vec)
  );

  function automatic bit raw_of(int i);
    if (i == 0) return nmi;
    if (i <= NE) return ext[i-1];
    return per[i-1-NE];
  endfunction

  function automatic bit en_of(int i);
    if (i == 0) return 1'b1;
    if (i <= NE) return ext_en[i-1];
    return per_en[i-1-NE];
  endfunction

  // Driver: advance the model with the currently driven inputs, queue the
  // expected outputs after the coming edge, then wait for the next negedge.
  task automatic step(input string tag);
    exp_t e;
    e.irq = 1'b0;
    e.vec = '0;
    e.tag = tag;
    for (int i = 0; i < NS; i++) begin
      bit r;
      bit c;
      r = raw_of(i) && !prev_m[i];
      c = ack && (int'(ackv) == BASE + i);
      pend_m[i] = r || (pend_m[i] && !c);
      prev_m[i] = raw_of(i);
    end
    for (int i = 0; i < NS; i++) begin
      if (!e.irq && pend_m[i] && (i == 0 || (en_of(i) && !gmask))) begin
        e.irq = 1'b1;
        e.vec = 6'(BASE + i);
      end
    end
    sb.push_back(e);
    @(negedge clk);
  endtask

  // Monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        total++;
        if (irq !== e.irq || vec !== e.vec) begin
          fails++;
          $display("FAIL %s: irq=%0b vec=%0d expected irq=%0b vec=%0d",
                   e.tag, irq, vec, e.irq, e.vec);
        end
      end
    end
  end

  task automatic do_ack(input int v, input string tag);
    ack = 1'b1;
    ackv = 6'(v);
    step(tag);
    ack = 1'b0;
    ackv = '0;
  endtask

  initial begin
    for (int i = 0; i < NS; i++) begin
      pend_m[i] = 0;
      prev_m[i] = 0;
    end
    repeat (3) @(negedge clk);
    total++;
    if (irq !== 1'b0 || vec !== 6'd0) begin
      fails++;
      $display("FAIL R1 during reset: irq=%0b vec=%0d expected irq=0 vec=0", irq, vec);
    end
    rst_n = 1'b1;
    @(negedge clk);
    step("R1 idle after reset");

    // R3/R7/R11: enabled external line 2 -> vector 6
    ext_en = '1;
    ext[2] = 1'b1;
    step("R7 R11 ext2 vector 6");
    ext[2] = 1'b0;
    step("R2 ext2 still pending");
    do_ack(6, "R9 ack ext2 clears");

    // R3: disabled internal 3 stays pending, then presented as 4+4+3=11
    per[3] = 1'b1;
    step("R3 disabled per3 hidden");
    per[3] = 1'b0;
    step("R3 disabled per3 hidden 2");
    per_en[3] = 1'b1;
    step("R3 R7 per3 enabled vector 11");
    do_ack(11, "R9 ack per3");

    // R4/R5: mask set, ext0 held back, NMI served
    gmask = 1'b1;
    ext[0] = 1'b1;
    step("R4 masked ext0 hidden");
    ext[0] = 1'b0;
    nmi = 1'b1;
    step("R5 nmi through mask vector 3");
    nmi = 1'b0;
    step("R5 nmi held");
    do_ack(3, "R4 ack nmi, ext0 still masked");
    gmask = 1'b0;
    step("R4 unmask shows ext0 vector 4");
    do_ack(4, "R9 ack ext0");

    // R6/R8: several at once
    per_en = '1;
    ext[1] = 1'b1;
    ext[3] = 1'b1;
    per[0] = 1'b1;
    step("R6 ext1 wins vector 5");
    ext = '0;
    per = '0;
    do_ack(9, "R9 ack of non-pending vector 9 no effect");
    do_ack(5, "R8 ext3 next vector 7");
    do_ack(7, "R8 per0 next vector 8");
    nmi = 1'b1;
    ext_en = '0;
    per_en = '0;
    per[5] = 1'b1;
    step("R5 nmi with all enables off, R6 over per0");
    nmi = 1'b0;
    do_ack(3, "R3 per0 hidden after nmi ack, enables off");
    per_en = '1;
    step("R6 per0 before per5");
    do_ack(8, "R8 per5 vector 13");
    do_ack(13, "R9 all cleared");

    // R10: new edge and ack of same source together
    ext_en = '1;
    ext[0] = 1'b1;
    step("R10 ext0 pending vector 4");
    ext[0] = 1'b0;
    step("R10 ext0 low");
    ext[0] = 1'b1;
    do_ack(4, "R10 edge plus ack keeps ext0");
    step("R10 ext0 still pending");
    do_ack(4, "R2 level held no new event");
    step("R2 level held stays idle");
    ext[0] = 1'b0;
    step("R1 final idle");
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: irq=%0b vec=%0d expected run to complete", irq, vec);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule